// File: doc/BRIEF.md
# Eight-Byte Grouped Flash Program Sequencer

This block is the command engine of a two-bank, byte-wide flash model. A host writes a setup command, then eight address/data pairs. The pairs must fill the eight byte slots of one aligned group. When the last pair arrives, the engine starts a timed program operation on that group. The operation can only clear bits: each stored byte becomes its old value ANDed with the new data. The array holds all-ones after reset, which stands in for an erased part.

While a program is in flight, a read to the busy bank returns a status byte, and a read to the other bank returns array contents. The host can pause the operation and later continue it. If the operation tried to raise a bit from 0 to 1, the bank stays in a failed state after completion. In that state the bank keeps answering reads with status until the host writes a reset command to it. Only one program can be open at a time. The `PROG_CYCLES` parameter sets the program duration in clock cycles.

Top module: `grp8_prog_seq`

## Requirements
- R1: After reset the registered read output is 0x00 and every array byte reads back as 0xFF.
- R2: Writing 0xA7 to any address in read mode opens a sequence. Eight further writes each latch one address/data pair. The ninth write starts programming at that clock edge, so a read of the busy bank in the next cycle returns status.
- R3: All eight pairs must share address bits [ADDR_W-1:3], which fixes both the bank and the group. A pair outside the group of the first pair aborts the sequence. The bank returns to read mode and the array is left unchanged.
- R4: A pair whose offset (address bits [2:0]) was already latched in the current sequence aborts it. The array is left unchanged.
- R5: The status byte is laid out as follows: bit7 = operation open (running or paused), bit6 = toggle, bit5 = error, bit2 = paused, all other bits 0. The toggle is cleared when programming starts. It inverts after each status read taken while running, so the first such read shows 0.
- R6: While a program is open or failed, reads to the other bank return array data.
- R7: Programming lasts `PROG_CYCLES` clock edges counted from the starting edge. A read captured on the last of them returns status, and a read one cycle later returns array data.
- R8: On completion each of the eight group bytes becomes its old value ANDed with the latched data byte for that offset.
- R9: If any latched bit is 1 where the stored bit was 0, completion leaves the bank failed. Reads to that bank return status with bit5 set and bit7 clear. Writing 0xF0 to an address in that bank returns it to read mode.
- R10: Writing 0xB0 to the busy bank pauses the operation, and 0x30 continues it. The cycle count is frozen while paused, so paused cycles lengthen the operation. While paused, reads to the group's own addresses return status, and reads to the bank's other addresses return array data.
- R11: While a program is open, a setup command, pairs or a pause command written to the other bank are ignored. They do not open a second program and do not alter the running one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Byte address; the top bit selects the bank |
| wdata | input | 8 | Write data or command code |
| rdata | output | 8 | Registered read data, valid the cycle after rd_en |

## Verification
The bench lands reads exactly on the final counted edge and on the edge after it. A design that miscounts the duration, or that keeps counting while paused, then returns array data one cycle early or status one cycle late. It aborts sequences through a group mismatch, a bank mismatch and a repeated offset, then sweeps the array. A design that commits partial groups or leaves the bank stuck in load mode shows a changed byte there. It also drives a program that tries to raise bits, and pushes a full sequence plus a pause command into the idle bank during a program. Sticky error handling and bank isolation must then hold, or the status byte and the final array sweep disagree with the arithmetic model.

// File: rtl/grp8_prog_seq.sv
module grp8_prog_seq #(
  parameter int ADDR_W      = 7,
  parameter int PROG_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int GRP_W = ADDR_W - 3;
  localparam int CNT_W = $clog2(PROG_CYCLES);
  localparam logic [7:0] CMD_SETUP  = 8'hA7;
  localparam logic [7:0] CMD_PAUSE  = 8'hB0;
  localparam logic [7:0] CMD_RESUME = 8'h30;
  localparam logic [7:0] CMD_CLEAR  = 8'hF0;

  typedef enum logic [2:0] {S_READ, S_LOAD, S_PROG, S_SUSP, S_FAIL} state_t;

  state_t           state;
  logic             abank;
  logic [GRP_W-1:0] grp;
  logic [7:0]       pmask;
  logic [7:0]       pdat [8];
  logic [CNT_W-1:0] cnt;
  logic             tog;
  logic [7:0]       mem  [DEPTH];
  logic             bad;

  wire             wbank  = addr[ADDR_W-1];
  wire [GRP_W-1:0] wgrp   = addr[ADDR_W-1:3];
  wire [2:0]       woff   = addr[2:0];
  wire             own_bk = (wbank == abank);
  wire             done   = (state == S_PROG) && (cnt == CNT_W'(PROG_CYCLES - 1));
  wire             first  = (pmask == 8'h00);
  wire             mis    = !first && ((wgrp != grp) || pmask[woff]);
  wire             full   = &(pmask | (8'h01 << woff));
  wire             open_s = (state == S_PROG) || (state == S_SUSP);
  wire [7:0]       status = {open_s, tog, state == S_FAIL, 2'b00, state == S_SUSP, 2'b00};

  always_comb begin
    bad = 1'b0;
    for (int i = 0; i < 8; i++)
      bad = bad | (|(~mem[{grp, 3'(i)}] & pdat[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_READ;
      abank <= 1'b0;
      grp   <= '0;
      pmask <= '0;
      cnt   <= '0;
      tog   <= 1'b0;
      for (int i = 0; i < 8; i++) pdat[i] <= '0;
    end else begin
      case (state)
        S_READ:
          if (wr_en && wdata == CMD_SETUP) begin
            state <= S_LOAD;
            pmask <= '0;
          end
        S_LOAD:
          if (wr_en) begin
            if (mis) begin
              state <= S_READ;
            end else begin
              pdat[woff]  <= wdata;
              pmask[woff] <= 1'b1;
              if (first) begin
                grp   <= wgrp;
                abank <= wbank;
              end
              if (full) begin
                state <= S_PROG;
                cnt   <= '0;
                tog   <= 1'b0;
              end
            end
          end
        S_PROG: begin
          if (done)
            state <= bad ? S_FAIL : S_READ;
          else if (wr_en && own_bk && wdata == CMD_PAUSE)
            state <= S_SUSP;
          else
            cnt <= cnt + CNT_W'(1);
          if (rd_en && addr[ADDR_W-1] == abank) tog <= ~tog;
        end
        S_SUSP:
          if (wr_en && own_bk && wdata == CMD_RESUME) state <= S_PROG;
        S_FAIL:
          if (wr_en && own_bk && wdata == CMD_CLEAR) state <= S_READ;
        default: state <= S_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (done) begin
      for (int i = 0; i < 8; i++)
        mem[{grp, 3'(i)}] <= mem[{grp, 3'(i)}] & pdat[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= 8'h00;
    else if (rd_en) begin
      if ((state == S_PROG || state == S_FAIL) && addr[ADDR_W-1] == abank)
        rdata <= status;
      else if (state == S_SUSP && wgrp == grp)
        rdata <= status;
      else
        rdata <= mem[addr];
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PROG_CYCLES - 1)); // R7

  AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_SUSP |=> $stable(cnt)); // R10

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FAIL && !(wr_en && wdata == CMD_CLEAR)) |=> state == S_FAIL); // R9

  AST_GROUP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LOAD && wr_en && !first && wgrp != grp) |=> state == S_READ); // R3

  AST_OTHER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && state == S_PROG && addr[ADDR_W-1] != abank) |=> rdata == $past(mem[addr])); // R6

  AST_SOLE_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    (open_s && wr_en && !own_bk) |=> $stable(abank) && $stable(grp)); // R11

  for (genvar g = 0; g < 8; g++) begin : g_clr
    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> mem[{grp, 3'(g)}] == ($past(mem[{grp, 3'(g)}]) & $past(pdat[g]))); // R8
  end

endmodule

// File: tb/test_grp8_prog_seq.sv
`timescale 1ns/1ps
module test_grp8_prog_seq;
  localparam int AW = 7;
  localparam int PC = 20;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  wire  [7:0]    rdata;

  int         checks = 0;
  int         errors = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] pd [8];
  logic [7:0] rv;

  grp8_prog_seq #(.ADDR_W(AW), .PROG_CYCLES(PC)) i_grp8_prog_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_group(input int base, input int seed);
    wr(base, 8'hA7);
    for (int k = 0; k < 8; k++) begin
      int off;
      off = (k * 5 + seed) & 7;
      wr(base + off, pd[off]);
    end
  endtask

  task automatic commit_model(input int base);
    for (int i = 0; i < 8; i++) model[base + i] = model[base + i] & pd[i];
  endtask

  task automatic sweep(input string tag, input int lo, input int hi);
    for (int a = lo; a <= hi; a++) begin
      rd(a, rv);
      chk(tag, rv, model[a]);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    idle(3);
    rst_n = 1'b1;
    chk("R1 reset rdata", rdata, 8'h00);
    sweep("R1 erased array", 0, DEPTH - 1);

    // R2 R5 R6 R7 R8: first program, bank0 group at 16
    for (int i = 0; i < 8; i++) pd[i] = ~8'(i * 37 + 5);
    load_group(16, 3);
    rd(16, rv); chk("R2 status after ninth write", rv, 8'h80);
    rd(20, rv); chk("R5 toggle inverts", rv, 8'hC0);
    rd(69, rv); chk("R6 other bank array", rv, model[69]);
    idle(PC - 4);
    rd(30, rv); chk("R7 busy on last edge", rv, 8'h80);
    commit_model(16);
    rd(17, rv); chk("R7 array after completion", rv, model[17]);
    sweep("R8 AND result", 16, 23);

    // R8: clearing-only reprogram, no error
    for (int i = 0; i < 8; i++) pd[i] = model[16 + i] & 8'h5A;
    load_group(16, 0);
    idle(PC + 2);
    commit_model(16);
    sweep("R8 second program", 16, 23);

    // R9: raise bits in byte 5
    for (int i = 0; i < 8; i++) pd[i] = model[16 + i];
    pd[5] = 8'hFF;
    load_group(16, 6);
    idle(PC + 2);
    rd(16, rv); chk("R9 failed status", rv, 8'h20);
    rd(64, rv); chk("R6 other bank while failed", rv, model[64]);
    rd(40, rv); chk("R9 sticky status", rv, 8'h20);
    wr(5, 8'hF0);
    commit_model(16);
    rd(21, rv); chk("R9 read mode after clear", rv, model[21]);

    // R3: group mismatch and bank mismatch aborts
    wr(32, 8'hA7); wr(32, 8'h00); wr(33, 8'h00); wr(34, 8'h00); wr(40, 8'h00);
    rd(32, rv); chk("R3 abort read mode", rv, model[32]);
    wr(35, 8'h00);
    wr(32, 8'hA7); wr(36, 8'h11); wr(64 + 37, 8'h11);
    rd(100, rv); chk("R3 bank abort read mode", rv, model[100]);
    idle(PC + 2);
    sweep("R3 array unchanged", 32, 47);
    sweep("R3 other bank unchanged", 96, 103);

    // R4: repeated offset
    wr(48, 8'hA7); wr(48, 8'h00); wr(49, 8'h00); wr(48, 8'h00);
    for (int k = 2; k < 8; k++) wr(48 + k, 8'h00);
    idle(PC + 2);
    sweep("R4 array unchanged", 48, 55);

    // R10: pause and continue, bank1 group at 88
    for (int i = 0; i < 8; i++) pd[i] = 8'(~(8'h01 << i)) & 8'hE7;
    load_group(88, 1);
    rd(88, rv); chk("R5 first status", rv, 8'h80);
    rd(89, rv); chk("R5 second status", rv, 8'hC0);
    wr(64, 8'hB0);
    rd(90, rv); chk("R10 paused status", rv, 8'h84);
    rd(64, rv); chk("R10 paused non-group array", rv, model[64]);
    idle(2 * PC);
    rd(95, rv); chk("R10 still paused", rv, 8'h84);
    wr(64, 8'h30);
    idle(PC - 3);
    rd(88, rv); chk("R10 count frozen", rv, 8'h80);
    commit_model(88);
    rd(89, rv); chk("R10 completes after resume", rv, model[89]);
    sweep("R8 paused program result", 88, 95);

    // R11: other bank traffic during a program
    for (int i = 0; i < 8; i++) pd[i] = 8'(i * 29) ^ 8'h3C;
    load_group(0, 2);
    wr(72, 8'hA7);
    for (int k = 0; k < 8; k++) wr(72 + k, 8'h00);
    wr(64, 8'hB0);
    idle(PC - 11);
    rd(3, rv); chk("R11 pause to other bank ignored", rv, 8'h80);
    commit_model(0);
    rd(3, rv); chk("R11 program completes", rv, model[3]);
    sweep("R11 other bank untouched", 72, 79);

    sweep("R8 final array", 0, DEPTH - 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule